// File: doc/BRIEF.md
# Noise-Shaped Buck/Boost Pulse Generator

This block drives the two legs of a four-switch non-inverting DC-DC converter from one fine-grained duty command. It runs once per switching period. A second-order error-feedback noise shaper cuts the wide command down to a short word, and a small counter-based pulse core turns that word into trailing-edge pulses. The short word has a top bit and a lower field. The top bit picks the leg. When it is clear (buck), the buck leg is modulated and the boost leg stays off. When it is set (boost), the buck leg is held fully on and the boost leg is modulated. The lower field is the pulse width in clocks.

Near the point where buck and boost meet, the noise shaper alternates the word between the two modes from period to period. The average conversion ratio therefore moves smoothly across that point. The block also produces a one-clock strobe for an external ADC, placed a fixed number of clocks before each period starts. The system clock runs at 2^CORE_W times the switching rate.

Top module: `bbd_dither_pwm`

## Requirements
- R1: While reset is held, buck_pwm, boost_pwm and adc_strobe are 0. After release, the first switching period (16 clocks) runs with a word of 0, so both legs stay low.
- R2: A period is 16 clocks. A pulse output can only rise in the first clock of a period.
- R3: The 5-bit word is updated once per period, from the command present in the last clock of the previous period. Command changes at any other time have no effect on the pulses.
- R4: Word bit 4 = 0 selects buck mode. buck_pwm is high for the first d clocks of the period, where d = word[3:0], and boost_pwm stays low for the whole period.
- R5: Word bit 4 = 1 selects boost mode. buck_pwm is high for all 16 clocks, and boost_pwm is high for the first d clocks. boost_pwm is never high while buck_pwm is low.
- R6: adc_strobe is high for exactly one clock per period, ADC_LEAD (default 2) clocks before the first clock of the next period.
- R7: The word follows v = cmd + 2·e[n-1] − e[n-2]. The word is floor(v/64) limited to 0..31, and e = v − 64·word is limited to −64..63.
- R8: For a steady command whose words stay below 16, the buck high time over 64 periods equals cmd within 8 clocks.
- R9: A command of 0 gives no pulses on either leg once the shaper has settled. A command of 2047 settles to a word of 31: buck fully on and boost high 15 of every 16 clocks.
- R10: The stored shaper error never leaves the range −64..63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 × switching rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | 11 | Unsigned fine duty command |
| buck_pwm | output | 1 | Buck leg pulse, registered |
| boost_pwm | output | 1 | Boost leg pulse, registered |
| adc_strobe | output | 1 | One-clock ADC sample request |

## Verification
Two things happen in the same clock: the ADC strobe and the sampling of the command into the shaper. The strobe is high in the last clock of the period, and at the end of that clock the command is taken. The bench provokes this overlap in two ways. It changes the command on every clock with pseudo-random values. It also applies a short full-scale burst that ends just before the sampling clock. A behavioural model that is updated every clock judges both legs and the strobe, so a sample taken one clock early or late shows up as a mismatch. Measured pulse totals check the leg steering and the average tracking.

// File: rtl/bbd_pkg.sv
`timescale 1ns/1ps
package bbd_pkg;
   // leg selection carried by the top bit of the truncated word
   typedef enum logic {
      LEG_BUCK  = 1'b0,
      LEG_BOOST = 1'b1
   } leg_mode_e;
endpackage

// File: rtl/bbd_phase_gen.sv
`timescale 1ns/1ps
module bbd_phase_gen #(
   parameter int CORE_W = 4,
   parameter int LEAD   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [CORE_W-1:0] cnt_q,
   output logic              wrap,
   output logic              strobe_q
);
   localparam int              STEPS  = 1 << CORE_W;
   localparam logic [CORE_W-1:0] LAST   = '1;
   localparam logic [CORE_W-1:0] STB_AT = CORE_W'(STEPS - LEAD);

   generate
      if (LEAD < 1 || LEAD >= STEPS) begin : g_bad_lead
         $error("bbd_phase_gen: LEAD must lie in 1..2^CORE_W-1");
      end
   endgenerate

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_q + 1'b1;
         strobe_q <= (cnt_q == STB_AT);
      end
   end
endmodule

// File: rtl/bbd_sd_trunc.sv
`timescale 1ns/1ps
module bbd_sd_trunc #(
   parameter int CMD_W = 11,
   parameter int OUT_W = 5,
   parameter int ORDER = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic [CMD_W-1:0]        cmd,
   output logic [OUT_W-1:0]        word_q,
   output logic signed [CMD_W+3:0] err_q
);
   localparam int ACC_W = CMD_W + 4;
   localparam int SHIFT = CMD_W - OUT_W;
   localparam logic signed [ACC_W-1:0] E_MAX = ACC_W'((2 ** SHIFT) - 1);
   localparam logic signed [ACC_W-1:0] E_MIN = -ACC_W'(2 ** SHIFT);
   localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((2 ** OUT_W) - 1);

   generate
      if (SHIFT < 1) begin : g_bad_width
         $error("bbd_sd_trunc: CMD_W must exceed OUT_W");
      end
   endgenerate

   logic signed [ACC_W-1:0] x_ext, fb, v, e_raw, e_new;
   logic [OUT_W-1:0]        y;

   assign x_ext = signed'(ACC_W'(cmd));

   generate
      if (ORDER == 2) begin : g_o2
         logic signed [ACC_W-1:0] e2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     e2_q <= '0;
            else if (step)  e2_q <= err_q;
         end
         assign fb = (err_q <<< 1) - e2_q;
      end else if (ORDER == 1) begin : g_o1
         assign fb = err_q;
      end else begin : g_bad_order
         $error("bbd_sd_trunc: ORDER must be 1 or 2");
         assign fb = '0;
      end
   endgenerate

   assign v = x_ext + fb;

   always_comb begin
      if (v < 0)                     y = '0;
      else if ((v >>> SHIFT) > Y_MAX) y = '1;
      else                           y = OUT_W'(v >>> SHIFT);
      e_raw = v - signed'(ACC_W'(y) << SHIFT);
      if (e_raw > E_MAX)      e_new = E_MAX;
      else if (e_raw < E_MIN) e_new = E_MIN;
      else                    e_new = e_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         err_q  <= '0;
      end else if (step) begin
         word_q <= y;
         err_q  <= e_new;
      end
   end
endmodule

// File: rtl/bbd_pwm_legs.sv
`timescale 1ns/1ps
module bbd_pwm_legs #(
   parameter int CORE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CORE_W-1:0] cnt,
   input  logic [CORE_W:0]   word,
   output logic              buck_q,
   output logic              boost_q
);
   import bbd_pkg::*;

   leg_mode_e mode;
   logic      on;

   assign mode = leg_mode_e'(word[CORE_W]);
   assign on   = (cnt < word[CORE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buck_q  <= 1'b0;
         boost_q <= 1'b0;
      end else begin
         buck_q  <= (mode == LEG_BOOST) ? 1'b1 : on;
         boost_q <= (mode == LEG_BOOST) ? on   : 1'b0;
      end
   end
endmodule

// File: rtl/bbd_dither_pwm.sv
`timescale 1ns/1ps
module bbd_dither_pwm #(
   parameter int CMD_W    = 11,
   parameter int CORE_W   = 4,
   parameter int ADC_LEAD = 2,
   parameter int SD_ORDER = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] duty_cmd,
   output logic             buck_pwm,
   output logic             boost_pwm,
   output logic             adc_strobe
);
   localparam int OUT_W = CORE_W + 1;
   localparam int ACC_W = CMD_W + 4;

   generate
      if (CORE_W < 1 || CMD_W <= OUT_W) begin : g_bad_cfg
         $error("bbd_dither_pwm: need CORE_W >= 1 and CMD_W > CORE_W+1");
      end
   endgenerate

   logic [CORE_W-1:0]       cnt_q;
   logic                    wrap;
   logic [OUT_W-1:0]        word_q;
   logic signed [ACC_W-1:0] err_q;

   bbd_phase_gen #(.CORE_W(CORE_W), .LEAD(ADC_LEAD)) u_phase (
      .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .wrap(wrap), .strobe_q(adc_strobe)
   );

   bbd_sd_trunc #(.CMD_W(CMD_W), .OUT_W(OUT_W), .ORDER(SD_ORDER)) u_sd (
      .clk(clk), .rst_n(rst_n), .step(wrap), .cmd(duty_cmd),
      .word_q(word_q), .err_q(err_q)
   );

   bbd_pwm_legs #(.CORE_W(CORE_W)) u_legs (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .word(word_q),
      .buck_q(buck_pwm), .boost_q(boost_pwm)
   );
endmodule

// File: rtl/bbd_dither_pwm_chk.sv
`timescale 1ns/1ps
module bbd_dither_pwm_chk #(
   parameter int CMD_W    = 11,
   parameter int CORE_W   = 4,
   parameter int ADC_LEAD = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [CORE_W-1:0]       cnt_q,
   input logic [CORE_W:0]         word_q,
   input logic signed [CMD_W+3:0] err_q,
   input logic                    buck_pwm,
   input logic                    boost_pwm,
   input logic                    adc_strobe
);
   localparam int SHIFT = CMD_W - CORE_W - 1;
   localparam int STEPS = 1 << CORE_W;
   localparam logic [CORE_W-1:0] FIRST   = CORE_W'(1);
   localparam logic [CORE_W-1:0] STB_CNT = CORE_W'((STEPS - ADC_LEAD + 1) % STEPS);

   AST_BOOST_NEEDS_BUCK: assert property (@(posedge clk) disable iff (!rst_n)
      boost_pwm |-> buck_pwm); // R5
   AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(buck_pwm) || $rose(boost_pwm)) |-> (cnt_q == FIRST)); // R2
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $stable(word_q)); // R3
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_strobe |=> !adc_strobe); // R6
   AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_strobe |-> (cnt_q == STB_CNT)); // R6
   AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q >= -(2 ** SHIFT)) && (err_q <= (2 ** SHIFT) - 1)); // R10
endmodule

bind bbd_dither_pwm bbd_dither_pwm_chk #(
   .CMD_W(CMD_W), .CORE_W(CORE_W), .ADC_LEAD(ADC_LEAD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .word_q(word_q), .err_q(err_q),
   .buck_pwm(buck_pwm), .boost_pwm(boost_pwm), .adc_strobe(adc_strobe)
);

// File: tb/bbd_dither_pwm_tb.sv
`timescale 1ns/1ps
module bbd_dither_pwm_tb;
   localparam int CMD_W = 11;
   localparam int LEAD  = 2;
   localparam int PER   = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CMD_W-1:0] duty_cmd = '0;
   logic             buck_pwm, boost_pwm, adc_strobe;

   always #10 clk = ~clk;

   bbd_dither_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd),
      .buck_pwm(buck_pwm), .boost_pwm(boost_pwm), .adc_strobe(adc_strobe)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   bit cmp_en = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference, advanced on every rising edge
   int m_cnt = 0, m_word = 0, m_e1 = 0, m_e2 = 0;
   bit m_buck = 0, m_boost = 0, m_stb = 0;

   always @(posedge clk) begin
      int v, y, e, d;
      bit nb, nbo, ns;
      if (!rst_n) begin
         m_cnt = 0; m_word = 0; m_e1 = 0; m_e2 = 0;
         m_buck = 0; m_boost = 0; m_stb = 0;
      end else begin
         d   = m_word % PER;
         nb  = (m_word >= PER) ? 1'b1 : (m_cnt < d);
         nbo = (m_word >= PER) ? (m_cnt < d) : 1'b0;
         ns  = (m_cnt == PER - LEAD);
         if (m_cnt == PER - 1) begin
            v = int'(duty_cmd) + 2 * m_e1 - m_e2;
            if (v < 0) y = 0; else y = v / 64;
            if (y > 31) y = 31;
            e = v - 64 * y;
            if (e > 63) e = 63;
            if (e < -64) e = -64;
            m_e2 = m_e1; m_e1 = e; m_word = y;
         end
         m_cnt = (m_cnt + 1) % PER;
         m_buck = nb; m_boost = nbo; m_stb = ns;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         check(buck_pwm == m_buck, "R4 R7", "buck_pwm", buck_pwm, m_buck);
         check(boost_pwm == m_boost, "R5 R7", "boost_pwm", boost_pwm, m_boost);
         check(adc_strobe == m_stb, "R6", "adc_strobe", adc_strobe, m_stb);
      end
   end

   task automatic measure(input int cyc, output int bh, output int boh);
      bh = 0; boh = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         bh += int'(buck_pwm);
         boh += int'(boost_pwm);
      end
   endtask

   task automatic wait_strobe();
      int k = 0;
      do begin @(negedge clk); k++; end while (!adc_strobe && k < 64);
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      int bh, boh, k;
      int unsigned seed = 32'h1234_5678;
      repeat (3) @(negedge clk);
      check(buck_pwm == 0, "R1", "buck in reset", buck_pwm, 0);
      check(boost_pwm == 0, "R1", "boost in reset", boost_pwm, 0);
      check(adc_strobe == 0, "R1", "strobe in reset", adc_strobe, 0);
      duty_cmd = 11'd2047;
      rst_n = 1'b1;
      cmp_en = 1'b1;
      measure(PER, bh, boh);
      check(bh + boh == 0, "R1", "pulses in first period", bh + boh, 0);

      // zero command after settling
      duty_cmd = '0;
      measure(8 * PER, bh, boh);
      measure(16 * PER, bh, boh);
      check(bh + boh == 0, "R9", "pulses at zero command", bh + boh, 0);

      // short burst that ends before the sampling clock
      wait_strobe();
      @(negedge clk);
      duty_cmd = 11'd2047;
      repeat (10) @(negedge clk);
      duty_cmd = '0;
      measure(3 * PER, bh, boh);
      check(bh + boh == 0, "R3", "pulses after mid-period burst", bh + boh, 0);

      // buck range average tracking
      duty_cmd = 11'd700;
      measure(8 * PER, bh, boh);
      measure(64 * PER, bh, boh);
      check(bh >= 692 && bh <= 708, "R8", "buck time at 700", bh, 700);
      check(boh == 0, "R4", "boost time in buck range", boh, 0);

      // strobe placement and period length
      wait_strobe();
      k = 0;
      do begin @(negedge clk); k++; end while (!buck_pwm && k < 40);
      check(k == LEAD, "R6", "strobe to period start", k, LEAD);
      wait_strobe();
      k = 0;
      do begin @(negedge clk); k++; end while (!adc_strobe && k < 40);
      check(k == PER, "R2", "strobe spacing", k, PER);

      duty_cmd = 11'd300;
      measure(8 * PER, bh, boh);
      measure(64 * PER, bh, boh);
      check(bh >= 292 && bh <= 308, "R8", "buck time at 300", bh, 300);

      // boost range
      duty_cmd = 11'd1500;
      measure(8 * PER, bh, boh);
      measure(64 * PER, bh, boh);
      check(bh == 64 * PER, "R5", "buck held on in boost", bh, 64 * PER);
      check(boh >= 468 && boh <= 484, "R5", "boost time at 1500", boh, 476);

      // dithering across the mode boundary, judged by the model
      duty_cmd = 11'd1020;
      measure(64 * PER, bh, boh);

      // full scale
      duty_cmd = 11'd2047;
      measure(8 * PER, bh, boh);
      measure(32 * PER, bh, boh);
      check(bh == 512, "R9", "buck at full scale", bh, 512);
      check(boh == 480, "R9", "boost at full scale", boh, 480);

      // command changing on every clock, including the sampling clock
      for (int i = 0; i < 200 * PER; i++) begin
         @(negedge clk);
         seed = seed * 32'd1103515245 + 32'd12345;
         duty_cmd = seed[26:16];
      end
      measure(4 * PER, bh, boh);
      finish_run();
   end
endmodule